// File: doc/BRIEF.md
# Serial Configuration Register for a Dual-Loop Frequency Synthesizer

This block takes configuration words from a three-wire serial port (serial clock, serial data, load strobe) and holds them in four latches that set up the two loops of a dual synthesizer. One loop runs at low frequency and one at high frequency. Each loop has a reference-divider latch and a feedback-divider latch. The three serial pins are asynchronous to the system clock. Each pin passes through a synchronizer, and the rising edges of the serial clock and the load strobe are detected in the system clock domain.

Serial data enters a 22-bit shift register, most significant bit first. The last two bits shifted in are the routing code. On a rising edge of the load strobe, the shifted word is copied into the one latch that the code selects. The other three latches keep their contents.

The latched fields drive the outputs directly. A per-loop status bit reports an illegal divider setting. Programming is accepted in every state, including while a loop is marked powered down.

Top module: `synth_cfg_port`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_dat` into a 22-bit register from the low end, so the first bit sent ends up most significant. When more than 22 bits are sent before a load, only the last 22 bits count.
- R2: On a rising edge of `ser_le`, word bits [1:0] select the destination latch: 00 is the low loop reference latch, 01 the high loop reference latch, 10 the low loop N latch, and 11 the high loop N latch. The other three latches are unchanged.
- R3: In a reference word, bits [16:2] are the reference divide value. Bit 17 is phase-detector polarity, bit 18 the charge-pump high-current select, bit 19 charge-pump tri-state, bit 20 lock-detect select, and bit 21 the divider-output select.
- R4: In an N word, bits [8:2] are the swallow count A and bits [19:9] the main count B. Bit 20 is the prescaler modulus select and bit 21 is powerdown.
- R5: The low loop keeps only four bits of A. Word bits [8:6] of a low loop N word have no effect, and `lo_a[6:4]` always reads zero.
- R6: The latch outputs change only at a rising edge of `ser_le`. They do not change while bits are being shifted, and they do not change while `ser_le` is held high during shifting.
- R7: `ratio_err[0]` is set for the low loop and `ratio_err[1]` for the high loop, whenever that loop's latched reference value is below 3, its B is below 3, or its A is greater than its B.
- R8: Synchronous reset clears all four latches and the shift register to zero. All mode bits are then zero, including the output selects and powerdown, and both `ratio_err` bits read 1.
- R9: A latched powerdown bit does not block programming. Words are still shifted and loaded into every latch while a loop's powerdown bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; rising edge latches the word |
| lo_ref_div | output | 15 | Low loop reference divide value |
| lo_pd_pol | output | 1 | Low loop phase-detector polarity |
| lo_cp_hi | output | 1 | Low loop charge-pump high current |
| lo_cp_tri | output | 1 | Low loop charge-pump tri-state |
| lo_ld_sel | output | 1 | Low loop lock-detect select |
| lo_fo_sel | output | 1 | Low loop divider-output select |
| hi_ref_div | output | 15 | High loop reference divide value |
| hi_pd_pol | output | 1 | High loop phase-detector polarity |
| hi_cp_hi | output | 1 | High loop charge-pump high current |
| hi_cp_tri | output | 1 | High loop charge-pump tri-state |
| hi_ld_sel | output | 1 | High loop lock-detect select |
| hi_fo_sel | output | 1 | High loop divider-output select |
| lo_a | output | 7 | Low loop swallow count (upper 3 bits zero) |
| lo_b | output | 11 | Low loop main count |
| lo_pre_sel | output | 1 | Low loop prescaler modulus select |
| lo_pwdn | output | 1 | Low loop powerdown |
| hi_a | output | 7 | High loop swallow count |
| hi_b | output | 11 | High loop main count |
| hi_pre_sel | output | 1 | High loop prescaler modulus select |
| hi_pwdn | output | 1 | High loop powerdown |
| ratio_err | output | 2 | Illegal divider flag per loop (bit 0 low, bit 1 high) |

## Verification
Random 22-bit words cover all four routing codes with arbitrary field contents. Comparing every latch after each load separates a wrong destination from a wrong bit position within a word. Directed words place the reference and B values at 2 and 3, and A at B and at B+1. These cases pin down the boundaries of the error flag.

Further directed patterns check that shifting alone leaves the latches unchanged. One sends a partial word. One sends a word with `ser_le` held high. One sends a word with extra leading bits, which must be pushed out. Another sets high bits in a low loop A field, which must be ignored. Loads made while powerdown is set show that programming continues in that state.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int WORD_W    = 22;
    localparam int CTRL_W    = 2;
    localparam int BODY_W    = WORD_W - CTRL_W;
    localparam int REF_W     = 15;
    localparam int A_W       = 7;
    localparam int B_W       = 11;
    localparam int LO_A_USED = 4;
    localparam int MIN_DIV   = 3;
    localparam int NUM_LOOPS = 2;

    // Routing code carried in the last two bits shifted in
    typedef enum logic [CTRL_W-1:0] {
        SEL_LO_REF = 2'b00,
        SEL_HI_REF = 2'b01,
        SEL_LO_N   = 2'b10,
        SEL_HI_N   = 2'b11
    } latch_sel_e;

    // Packed from MSB so that it lines up with word[21:2]
    typedef struct packed {
        logic             fo_sel;
        logic             ld_sel;
        logic             cp_tri;
        logic             cp_hi;
        logic             pd_pol;
        logic [REF_W-1:0] div;
    } ref_cfg_t;

    typedef struct packed {
        logic           pwdn;
        logic           pre_sel;
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } n_cfg_t;

    function automatic ref_cfg_t unpack_ref(input logic [BODY_W-1:0] body);
        return ref_cfg_t'(body);
    endfunction

    function automatic n_cfg_t unpack_n(input logic [BODY_W-1:0] body,
                                        input logic [A_W-1:0]    a_mask);
        n_cfg_t n;
        n   = n_cfg_t'(body);
        n.a = n.a & a_mask;
        return n;
    endfunction

    function automatic logic ratio_bad(input ref_cfg_t r, input n_cfg_t n);
        return (r.div < REF_W'(MIN_DIV)) ||
               (n.b < B_W'(MIN_DIV)) ||
               (B_W'(n.a) > n.b);
    endfunction

endpackage

// File: rtl/synth_cfg_sampler.sv
module synth_cfg_sampler
    import synth_cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic sdat_i,
    input  logic sle_i,
    output logic sclk_rise_o,
    output logic sdat_o,
    output logic sle_rise_o
);
    localparam int NPIN = 3;

    logic [STAGES-1:0][NPIN-1:0] chain;
    logic [NPIN-1:0]             synced;
    logic [NPIN-1:0]             last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= '0;
        end else begin
            chain[0] <= {sle_i, sdat_i, sclk_i};
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
            last <= synced;
        end
    end

    assign synced      = chain[STAGES-1];
    assign sclk_rise_o = synced[0] & ~last[0];
    assign sdat_o      = synced[1];
    assign sle_rise_o  = synced[2] & ~last[2];

endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
        end else if (shift_en) begin
            word_o <= {word_o[WORD_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/synth_cfg_latches.sv
module synth_cfg_latches
    import synth_cfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [WORD_W-1:0]          word,
    output ref_cfg_t [NUM_LOOPS-1:0]   ref_q,
    output n_cfg_t   [NUM_LOOPS-1:0]   n_q
);
    logic [CTRL_W-1:0] sel;
    logic [BODY_W-1:0] body;

    assign sel  = word[CTRL_W-1:0];
    assign body = word[WORD_W-1:CTRL_W];

    generate
        for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
            localparam logic          LOOP_BIT = 1'(i);
            localparam int            A_USED   = (i == 0) ? LO_A_USED : A_W;
            localparam logic [A_W-1:0] A_MASK  = A_W'((1 << A_USED) - 1);

            ref_cfg_t ref_r;
            n_cfg_t   n_r;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ref_r <= '0;
                    n_r   <= '0;
                end else if (load) begin
                    if (sel == {1'b0, LOOP_BIT}) begin
                        ref_r <= unpack_ref(body);
                    end
                    if (sel == {1'b1, LOOP_BIT}) begin
                        n_r <= unpack_n(body, A_MASK);
                    end
                end
            end

            assign ref_q[i] = ref_r;
            assign n_q[i]   = n_r;
        end
    endgenerate
endmodule

// File: rtl/synth_cfg_ratio_chk.sv
module synth_cfg_ratio_chk
    import synth_cfg_pkg::*;
(
    input  ref_cfg_t [NUM_LOOPS-1:0] ref_q,
    input  n_cfg_t   [NUM_LOOPS-1:0] n_q,
    output logic     [NUM_LOOPS-1:0] err_o
);
    generate
        for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_err
            assign err_o[i] = ratio_bad(ref_q[i], n_q[i]);
        end
    endgenerate
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_dat,
    input  logic        ser_le,
    output logic [14:0] lo_ref_div,
    output logic        lo_pd_pol,
    output logic        lo_cp_hi,
    output logic        lo_cp_tri,
    output logic        lo_ld_sel,
    output logic        lo_fo_sel,
    output logic [14:0] hi_ref_div,
    output logic        hi_pd_pol,
    output logic        hi_cp_hi,
    output logic        hi_cp_tri,
    output logic        hi_ld_sel,
    output logic        hi_fo_sel,
    output logic [6:0]  lo_a,
    output logic [10:0] lo_b,
    output logic        lo_pre_sel,
    output logic        lo_pwdn,
    output logic [6:0]  hi_a,
    output logic [10:0] hi_b,
    output logic        hi_pre_sel,
    output logic        hi_pwdn,
    output logic [1:0]  ratio_err
);
    logic              sclk_rise;
    logic              sdat;
    logic              le_rise;
    logic [WORD_W-1:0] shift_word;
    ref_cfg_t [NUM_LOOPS-1:0] ref_q;
    n_cfg_t   [NUM_LOOPS-1:0] n_q;

    synth_cfg_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk         (clk),
        .rst         (rst),
        .sclk_i      (ser_clk),
        .sdat_i      (ser_dat),
        .sle_i       (ser_le),
        .sclk_rise_o (sclk_rise),
        .sdat_o      (sdat),
        .sle_rise_o  (le_rise)
    );

    synth_cfg_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise),
        .bit_in   (sdat),
        .word_o   (shift_word)
    );

    synth_cfg_latches u_latches (
        .clk   (clk),
        .rst   (rst),
        .load  (le_rise),
        .word  (shift_word),
        .ref_q (ref_q),
        .n_q   (n_q)
    );

    synth_cfg_ratio_chk u_ratio (
        .ref_q (ref_q),
        .n_q   (n_q),
        .err_o (ratio_err)
    );

    assign lo_ref_div = ref_q[0].div;
    assign lo_pd_pol  = ref_q[0].pd_pol;
    assign lo_cp_hi   = ref_q[0].cp_hi;
    assign lo_cp_tri  = ref_q[0].cp_tri;
    assign lo_ld_sel  = ref_q[0].ld_sel;
    assign lo_fo_sel  = ref_q[0].fo_sel;
    assign hi_ref_div = ref_q[1].div;
    assign hi_pd_pol  = ref_q[1].pd_pol;
    assign hi_cp_hi   = ref_q[1].cp_hi;
    assign hi_cp_tri  = ref_q[1].cp_tri;
    assign hi_ld_sel  = ref_q[1].ld_sel;
    assign hi_fo_sel  = ref_q[1].fo_sel;
    assign lo_a       = n_q[0].a;
    assign lo_b       = n_q[0].b;
    assign lo_pre_sel = n_q[0].pre_sel;
    assign lo_pwdn    = n_q[0].pwdn;
    assign hi_a       = n_q[1].a;
    assign hi_b       = n_q[1].b;
    assign hi_pre_sel = n_q[1].pre_sel;
    assign hi_pwdn    = n_q[1].pwdn;

endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk
    import synth_cfg_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     le_rise,
    input logic [WORD_W-1:0]        shift_word,
    input ref_cfg_t [NUM_LOOPS-1:0] ref_q,
    input n_cfg_t   [NUM_LOOPS-1:0] n_q
);
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !le_rise |=> ($stable(ref_q) && $stable(n_q)));

    assert_keep_loref_R2: assert property (@(posedge clk) disable iff (rst)
        (le_rise && shift_word[1:0] != 2'b00) |=> $stable(ref_q[0]));
    assert_keep_hiref_R2: assert property (@(posedge clk) disable iff (rst)
        (le_rise && shift_word[1:0] != 2'b01) |=> $stable(ref_q[1]));
    assert_keep_lon_R2: assert property (@(posedge clk) disable iff (rst)
        (le_rise && shift_word[1:0] != 2'b10) |=> $stable(n_q[0]));
    assert_keep_hin_R2: assert property (@(posedge clk) disable iff (rst)
        (le_rise && shift_word[1:0] != 2'b11) |=> $stable(n_q[1]));

    assert_hiref_load_R3: assert property (@(posedge clk) disable iff (rst)
        (le_rise && shift_word[1:0] == 2'b01) |=> (ref_q[1] == $past(shift_word[21:2])));

    assert_hin_load_R4: assert property (@(posedge clk) disable iff (rst)
        (le_rise && shift_word[1:0] == 2'b11) |=> (n_q[1] == $past(shift_word[21:2])));

    assert_lo_a_narrow_R5: assert property (@(posedge clk) disable iff (rst)
        n_q[0].a[6:4] == 3'b000);

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (ref_q == '0 && n_q == '0));

    assert_pwdn_load_R9: assert property (@(posedge clk) disable iff (rst)
        (le_rise && shift_word[1:0] == 2'b00 && n_q[0].pwdn) |=>
        (ref_q[0] == $past(shift_word[21:2])));
endmodule

bind synth_cfg_port synth_cfg_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .le_rise    (le_rise),
    .shift_word (shift_word),
    .ref_q      (ref_q),
    .n_q        (n_q)
);

// File: tb/tb_synth_cfg_port.sv
`timescale 1ns/1ps
module tb_synth_cfg_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [14:0] lo_ref_div, hi_ref_div;
    logic lo_pd_pol, lo_cp_hi, lo_cp_tri, lo_ld_sel, lo_fo_sel;
    logic hi_pd_pol, hi_cp_hi, hi_cp_tri, hi_ld_sel, hi_fo_sel;
    logic [6:0] lo_a, hi_a;
    logic [10:0] lo_b, hi_b;
    logic lo_pre_sel, lo_pwdn, hi_pre_sel, hi_pwdn;
    logic [1:0] ratio_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Expected latch contents, laid out as word bits [21:2]
    logic [19:0] e_lo_ref = '0, e_hi_ref = '0, e_lo_n = '0, e_hi_n = '0;

    always #2 clk = ~clk;

    synth_cfg_port dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .lo_ref_div(lo_ref_div), .lo_pd_pol(lo_pd_pol), .lo_cp_hi(lo_cp_hi),
        .lo_cp_tri(lo_cp_tri), .lo_ld_sel(lo_ld_sel), .lo_fo_sel(lo_fo_sel),
        .hi_ref_div(hi_ref_div), .hi_pd_pol(hi_pd_pol), .hi_cp_hi(hi_cp_hi),
        .hi_cp_tri(hi_cp_tri), .hi_ld_sel(hi_ld_sel), .hi_fo_sel(hi_fo_sel),
        .lo_a(lo_a), .lo_b(lo_b), .lo_pre_sel(lo_pre_sel), .lo_pwdn(lo_pwdn),
        .hi_a(hi_a), .hi_b(hi_b), .hi_pre_sel(hi_pre_sel), .hi_pwdn(hi_pwdn),
        .ratio_err(ratio_err)
    );

    function automatic logic exp_err(input logic [19:0] r, input logic [19:0] n);
        logic [14:0] rd;
        logic [6:0]  a;
        logic [10:0] b;
        rd = r[14:0];
        a  = n[6:0];
        b  = n[17:7];
        return (rd < 15'd3) || (b < 11'd3) || ({4'b0, a} > b);
    endfunction

    function automatic logic [21:0] mk_ref(input logic hi, input logic [4:0] modes,
                                           input logic [14:0] div);
        return {modes, div, 1'b0, hi};
    endfunction

    function automatic logic [21:0] mk_n(input logic hi, input logic pwdn, input logic pre,
                                         input logic [10:0] b, input logic [6:0] a);
        return {pwdn, pre, b, a, 1'b1, hi};
    endfunction

    // R2: routing model; R5: low loop keeps four bits of A
    task automatic model_load(input logic [21:0] w);
        case (w[1:0])
            2'b00: e_lo_ref = w[21:2];
            2'b01: e_hi_ref = w[21:2];
            2'b10: e_lo_n   = {w[21:9], 3'b000, w[5:2]};
            default: e_hi_n = w[21:2];
        endcase
    endtask

    task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " lo_ref"}, {lo_fo_sel, lo_ld_sel, lo_cp_tri, lo_cp_hi, lo_pd_pol, lo_ref_div}, e_lo_ref);
        chk({req, " hi_ref"}, {hi_fo_sel, hi_ld_sel, hi_cp_tri, hi_cp_hi, hi_pd_pol, hi_ref_div}, e_hi_ref);
        chk({req, " lo_n"}, {lo_pwdn, lo_pre_sel, lo_b, lo_a}, e_lo_n);
        chk({req, " hi_n"}, {hi_pwdn, hi_pre_sel, hi_b, hi_a}, e_hi_n);
        chk({req, " R7 err"}, {18'b0, ratio_err},
            {18'b0, exp_err(e_hi_ref, e_hi_n), exp_err(e_lo_ref, e_lo_n)});
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(3);
            ser_clk = 1'b0;
        end
        wait_clk(3);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_clk(4);
        ser_le = 1'b0;
        wait_clk(8);
    endtask

    task automatic send_word(input logic [21:0] w, input string req);
        shift_bits({10'b0, w}, 22);
        pulse_le();
        model_load(w);
        check_all(req);
    endtask

    initial begin
        logic [21:0] w;
        void'($urandom(32'd20240611));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        check_all("R8 reset");

        // R3 / R4 directed layouts, one per latch
        send_word(mk_ref(1'b0, 5'b10101, 15'd1234), "R3 R2 lo ref");
        send_word(mk_ref(1'b1, 5'b01010, 15'd32767), "R3 R2 hi ref");
        send_word(mk_n(1'b1, 1'b0, 1'b1, 11'd2047, 7'd127), "R4 R2 hi n");
        send_word(mk_n(1'b0, 1'b0, 1'b1, 11'd100, 7'd15), "R4 R2 lo n");

        // R5: bits 8:6 of a low loop A field are dropped
        send_word(mk_n(1'b0, 1'b1, 1'b0, 11'd50, 7'b1110101), "R5 lo A narrow");

        // R7 boundaries
        send_word(mk_ref(1'b0, 5'b0, 15'd3), "R7 ref=3");
        send_word(mk_ref(1'b0, 5'b0, 15'd2), "R7 ref=2");
        send_word(mk_ref(1'b0, 5'b0, 15'd3), "R7 ref=3 again");
        send_word(mk_n(1'b0, 1'b0, 1'b0, 11'd2, 7'd0), "R7 B=2");
        send_word(mk_n(1'b0, 1'b0, 1'b0, 11'd9, 7'd9), "R7 A=B");
        send_word(mk_n(1'b1, 1'b0, 1'b0, 11'd9, 7'd10), "R7 A=B+1");
        send_word(mk_n(1'b1, 1'b0, 1'b0, 11'd10, 7'd10), "R7 hi A=B");

        // R6: half a word shifted, nothing latched yet
        shift_bits(32'h7ff, 11);
        check_all("R6 mid shift");
        shift_bits(32'h001, 11);
        check_all("R6 shifted no load");
        pulse_le();
        model_load({11'h7ff, 11'h001});
        check_all("R6 late load");

        // R6: shifting with the strobe held high does not relatch
        ser_le = 1'b1;
        wait_clk(8);
        model_load({11'h7ff, 11'h001});
        check_all("R6 rise with same word");
        shift_bits({10'b0, mk_ref(1'b1, 5'b11111, 15'd77)}, 22);
        check_all("R6 le held high");
        ser_le = 1'b0;
        wait_clk(8);
        check_all("R6 le fall");

        // R1: leading extra bits are pushed out
        shift_bits(32'h7, 3);
        send_word(mk_ref(1'b1, 5'b00110, 15'd4242), "R1 extra leading bits");

        // R9: powerdown set, programming still works
        send_word(mk_n(1'b0, 1'b1, 1'b0, 11'd40, 7'd5), "R9 lo pwdn set");
        send_word(mk_n(1'b1, 1'b1, 1'b1, 11'd60, 7'd6), "R9 hi pwdn set");
        send_word(mk_ref(1'b0, 5'b11001, 15'd555), "R9 lo ref while pwdn");
        send_word(mk_ref(1'b1, 5'b00011, 15'd666), "R9 hi ref while pwdn");
        send_word(mk_n(1'b0, 1'b0, 1'b0, 11'd41, 7'd4), "R9 lo power up");

        // R1 R2 R3 R4 random words
        for (int k = 0; k < 40; k++) begin
            w = 22'($urandom());
            send_word(w, "R2 random");
        end

        // R8: reset in the middle of use
        rst = 1'b1;
        wait_clk(2);
        rst = 1'b0;
        e_lo_ref = '0; e_hi_ref = '0; e_lo_n = '0; e_hi_n = '0;
        wait_clk(2);
        check_all("R8 second reset");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule